// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Protection Policy

This block holds the nonvolatile part of a serial EEPROM's status register: the hardware-protect enable flag and the two block-protect bits. It combines them with the live write-in-progress and write-enable-latch flags, which the surrounding controller supplies, into the byte returned by a status read. Serial shifting and command decoding live elsewhere. The controller presents a completed status-write byte with a one-cycle strobe.

The block decides whether that status write may take effect. A write needs the write-enable latch to be set. When the protect enable flag is set, it also needs the active-low write-protect pin to be high. The pin is looked at only in the strobe cycle. If the write is taken, the block pulses a done output, which the controller uses to clear its write-enable latch.

For array writes, the controller places an address on a check port. A combinational allow output tells it whether the block-protect bits permit a write to that address. Protected regions always grow downward from the top of the address space.

Top module: `eesr_guard`

## Requirements
- R1: After reset, the protect enable flag and both block-protect bits are 0. The done output is 0.
- R2: The read byte is laid out as follows: bit 7 is the protect enable flag, bits 3:2 are the block-protect bits (bit 3 is the upper one), bit 1 is wel_i and bit 0 is wip_i. Bits 6:4 always read 0.
- R3: A taken status write loads data bit 7 into the protect enable flag and data bits 3:2 into the block-protect bits. Data bits 6:4 and 1:0 have no effect.
- R4: A strobe while wel_i is 0 is refused. The stored bits keep their value and no done pulse is produced.
- R5: A strobe while the protect enable flag is 1 and wp_ni is 0 is refused. The stored bits keep their value and no done pulse is produced.
- R6: A strobe with wel_i at 1, the protect enable flag at 1 and wp_ni at 1 is taken. This includes a write that clears the protect enable flag.
- R7: While the protect enable flag is 0, wp_ni has no effect: a strobe with wel_i at 1 is taken even with wp_ni at 0.
- R8: The accept decision uses only the values present in the strobe cycle. wp_ni going low in the following cycle does not undo a taken write.
- R9: The new stored bits and the one-cycle done pulse both appear in the cycle after a taken strobe.
- R10: chk_allow_o is 1 unless the address is protected. With block-protect bits 00 nothing is protected. With 01 the top quarter is protected (both address MSBs 1). With 10 the top half is protected (address MSB 1). With 11 every address is protected.
- R11: chk_allow_o, and the wel and wip bits of the read byte, follow their inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wrsr_stb_i | input | 1 | One-cycle strobe: a status-write byte is complete |
| wrsr_data_i | input | 8 | Status-write data byte |
| wp_ni | input | 1 | Write-protect pin, active low |
| wel_i | input | 1 | Live write-enable latch |
| wip_i | input | 1 | Live write-in-progress flag |
| rdsr_data_o | output | 8 | Status byte for a status read |
| wrsr_done_o | output | 1 | Pulse: a status write was taken; clear the write-enable latch |
| chk_addr_i | input | ADDR_W | Array address under test |
| chk_allow_o | output | 1 | The address under test may be written |

## Verification
Status-write results are registered. For each strobe, the bench drives the inputs just after a falling edge and checks the stored bits and the done pulse at the next falling edge, half a cycle after the capturing rising edge. One further cycle later it checks that the done pulse has dropped. The allow output and the live flag bits are combinational, so they are checked in the same low phase in which their inputs were changed. The bench keeps its own model of the stored bits. It sweeps every data byte against every combination of latch and pin, then sweeps every address of a small address space under each block-protect setting.

// File: rtl/eesr_pkg.sv
package eesr_pkg;
  localparam int unsigned SR_W      = 8;
  localparam int unsigned POS_WPEN  = 7;
  localparam int unsigned POS_BP_HI = 3;
  localparam int unsigned POS_BP_LO = 2;
  localparam int unsigned POS_WEL   = 1;
  localparam int unsigned POS_WIP   = 0;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;

  typedef struct packed {
    logic  wpen;
    prot_e bp;
  } nv_t;
endpackage

// File: rtl/eesr_policy.sv
module eesr_policy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_stb_i,
  input  logic wel_i,
  input  logic wp_ni,
  input  logic wpen_i,
  output logic grant_o,
  output logic done_o
);
  logic hw_lock;
  logic done_q;

  // pin only matters once the enable flag is set
  assign hw_lock = wpen_i & ~wp_ni;
  assign grant_o = wr_stb_i & wel_i & ~hw_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= grant_o;
  end
  assign done_o = done_q;

  assert_needs_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !wel_i) |=> !done_o);
  assert_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wpen_i && !wp_ni) |=> !done_o);
  assert_pin_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wel_i && !wpen_i) |=> done_o);
  assert_unlocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wel_i && wp_ni) |=> done_o);
  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> !done_o);
endmodule

// File: rtl/eesr_store.sv
module eesr_store
  import eesr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  output nv_t             nv_o
);
  nv_t nv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q <= '{wpen: 1'b0, bp: PROT_NONE};
    end else if (load_i) begin
      nv_q.wpen <= data_i[POS_WPEN];
      nv_q.bp   <= prot_e'(data_i[POS_BP_HI:POS_BP_LO]);
    end
  end
  assign nv_o = nv_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(nv_q));
  assert_load_wpen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (nv_q.wpen == $past(data_i[POS_WPEN])));
  assert_load_bp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (nv_q.bp == $past(data_i[POS_BP_HI:POS_BP_LO])));
endmodule

// File: rtl/eesr_region.sv
module eesr_region
  import eesr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  prot_e             bp_i,
  output logic              allow_o
);
  localparam int unsigned MSB = ADDR_W - 1;
  localparam int unsigned NSB = (ADDR_W > 1) ? ADDR_W - 2 : 0;

  logic top_half;
  logic top_quarter;

  generate
    if (ADDR_W > 1) begin : g_wide
      assign top_half    = addr_i[MSB];
      assign top_quarter = addr_i[MSB] & addr_i[NSB];
    end else begin : g_narrow
      assign top_half    = addr_i[0];
      assign top_quarter = addr_i[0];
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      PROT_NONE:    allow_o = 1'b1;
      PROT_QUARTER: allow_o = ~top_quarter;
      PROT_HALF:    allow_o = ~top_half;
      default:      allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eesr_guard.sv
module eesr_guard
  import eesr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrsr_stb_i,
  input  logic [SR_W-1:0]   wrsr_data_i,
  input  logic              wp_ni,
  input  logic              wel_i,
  input  logic              wip_i,
  output logic [SR_W-1:0]   rdsr_data_o,
  output logic              wrsr_done_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              chk_allow_o
);
  nv_t  nv;
  logic grant;

  eesr_policy u_policy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wrsr_stb_i),
    .wel_i    (wel_i),
    .wp_ni    (wp_ni),
    .wpen_i   (nv.wpen),
    .grant_o  (grant),
    .done_o   (wrsr_done_o)
  );

  eesr_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (grant),
    .data_i (wrsr_data_i),
    .nv_o   (nv)
  );

  eesr_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i  (chk_addr_i),
    .bp_i    (nv.bp),
    .allow_o (chk_allow_o)
  );

  always_comb begin
    rdsr_data_o                      = '0;
    rdsr_data_o[POS_WPEN]            = nv.wpen;
    rdsr_data_o[POS_BP_HI:POS_BP_LO] = nv.bp;
    rdsr_data_o[POS_WEL]             = wel_i;
    rdsr_data_o[POS_WIP]             = wip_i;
  end

  assert_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdsr_data_o[POS_BP_HI:POS_BP_LO] == 2'b00) |-> chk_allow_o);
  assert_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdsr_data_o[POS_BP_HI:POS_BP_LO] == 2'b11) |-> !chk_allow_o);
  assert_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdsr_data_o[POS_BP_HI:POS_BP_LO] != 2'b00) && (&chk_addr_i)) |-> !chk_allow_o);
  assert_zero_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdsr_data_o[6:4] == 3'b000);
  assert_done_changes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_done_o |-> (rdsr_data_o[POS_WPEN] == $past(wrsr_data_i[POS_WPEN])));
endmodule

// File: tb/eesr_guard_tb.sv
module eesr_guard_tb;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb = 1'b0;
  logic [7:0]    data = 8'h00;
  logic          wp_n = 1'b1;
  logic          wel = 1'b0;
  logic          wip = 1'b0;
  logic [7:0]    rdsr;
  logic          done;
  logic [AW-1:0] addr = '0;
  logic          allow;

  int n_run = 0;
  int n_fail = 0;
  logic       m_wpen = 1'b0;
  logic [1:0] m_bp = 2'b00;

  always #2 clk = ~clk;

  eesr_guard #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wrsr_stb_i(stb), .wrsr_data_i(data),
    .wp_ni(wp_n), .wel_i(wel), .wip_i(wip), .rdsr_data_o(rdsr),
    .wrsr_done_o(done), .chk_addr_i(addr), .chk_allow_o(allow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sr();
    return {m_wpen, 3'b000, m_bp, wel, wip};
  endfunction

  // drive strobe in a low phase, check after the capturing edge
  task automatic wrsr(input logic [7:0] d, input logic w, input logic p,
                      input logic drop_wp_after);
    logic take;
    @(negedge clk);
    data = d; wel = w; wp_n = p; stb = 1'b1;
    wip = d[0] ^ w;
    take = w & (~m_wpen | p);
    @(negedge clk);
    stb = 1'b0;
    if (drop_wp_after) wp_n = 1'b0;
    if (take) begin m_wpen = d[7]; m_bp = d[3:2]; end
    chk(take ? "R9 done pulse" : (w ? "R5 refused" : "R4 refused"), done, take);
    chk("R3 stored bits", rdsr, exp_sr());
    @(negedge clk);
    chk("R9 single pulse", done, 0);
    chk("R8 kept after wp", rdsr, exp_sr());
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #9;
    chk("R1 reset sr", rdsr, 8'h00);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wel = 1'b1; wip = 1'b1;
    #0.5;
    chk("R11 live flags", rdsr, 8'h03);
    chk("R2 layout live", rdsr, exp_sr());
    wel = 1'b0; wip = 1'b0;

    // directed corners
    wrsr(8'h8C, 1'b0, 1'b1, 1'b0);  // R4 no latch
    wrsr(8'h8C, 1'b1, 1'b0, 1'b0);  // R7 pin low, flag clear
    chk("R7 wpen set", rdsr[7], 1);
    wrsr(8'h00, 1'b1, 1'b0, 1'b0);  // R5 locked
    chk("R5 still locked", rdsr, 8'h8C | {6'b0, wel, wip});
    wrsr(8'h84, 1'b1, 1'b1, 1'b1);  // R6 + R8 pin drops after
    chk("R6 bp updated", rdsr[3:2], 2'b01);
    wrsr(8'h70, 1'b1, 1'b1, 1'b0);  // R6 clears flag, R3 bits 6:4 ignored
    chk("R6 flag cleared", rdsr[7], 0);
    chk("R2 bits 6:4 zero", rdsr[6:4], 0);

    // near-exhaustive sweep
    for (int d = 0; d < 256; d++)
      for (int c = 0; c < 4; c++)
        wrsr(8'(d), c[0], c[1], 1'b0);

    // region sweep, every bp, every address
    for (int b = 0; b < 4; b++) begin
      wrsr(8'(b << 2), 1'b1, 1'b1, 1'b0);
      for (int a = 0; a < (1 << AW); a++) begin
        int lim;
        @(negedge clk);
        addr = AW'(a);
        #0.5;
        lim = (b == 0) ? 64 : (b == 1) ? 48 : (b == 2) ? 32 : 0;
        chk("R10 allow map", allow, (a < lim) ? 1 : 0);
        chk("R11 allow same cycle", allow, (a < lim) ? 1 : 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule